// File: doc/BRIEF.md
# Single-Wire Bus Slave Write Checker

This block is the write path of a slave device on a single-wire sensor management bus. A bit-level front end turns line activity into single-cycle symbols: a start strobe, a data-bit strobe with its value, and a level that shows the bus is idle. From these symbols the block assembles the frame. First come the device number, the internal register address and the direction flag. Then comes a data field whose width depends on the addressed register. The block checks an even-parity bit and answers with an acknowledge symbol. Only a positive acknowledge produces a one-cycle register commit strobe that carries the address and the data.

A failed check makes the slave refuse the write. It also sets a sticky bus-error flag and arms an attention request. That request goes out only while the bus is idle and enabled, and only if no attention has been seen on the bus since the last status read. Frames for other devices are followed to their end and left alone. A new start strobe drops a partial frame quietly. A partial frame is kept without time limit until its remaining bits arrive.

Top module: `swb_wr_slave`

## Requirements
- R1: A frame is the start strobe followed by bits taken most significant first: a 3-bit device number, a 5-bit register address, a direction flag (0 = write, 1 = read), the data field, then the parity bit. A committed write presents that address on `wr_addr` and the data right-justified on `wr_data`.
- R2: Addresses 0 to 7 carry an 8-bit data field. Addresses 8 to 15 carry a 16-bit data field.
- R3: In the cycle after the parity bit's strobe, a one-cycle `ack_stb` appears. `ack_val` is 1 when the count of ones over header, data and parity is even, and 0 otherwise.
- R4: `wr_en` pulses only together with `ack_stb` and `ack_val` = 1. A refused write produces no commit.
- R5: A refused write (`ack_val` = 0) sets `ber` one cycle later. `ber` stays set until `status_rd` or `bus_rst`.
- R6: `attn_req` is a one-cycle pulse after a refused write. It is issued only while `attn_en` and `bus_idle` are high, and only if no attention (own or `attn_obs`) has occurred since the last `status_rd`. A pending request waits while `attn_en` is low.
- R7: A start strobe in mid-frame drops the frame with no acknowledge, no commit, no `ber` and no attention. The new frame then proceeds normally.
- R8: Bits beyond the expected data width are not data. The first of them is taken as the parity bit. Bits after the acknowledge are ignored until the next start.
- R9: A frame missing bits waits with no time limit. It completes normally when the remaining bits and the parity bit arrive.
- R10: A frame whose device number differs from `dev_strap` produces no acknowledge, no commit and no `ber`.
- R11: A write to an address above 15 is refused (`ack_val` = 0).
- R12: A frame with the direction flag at 1 produces no acknowledge and no commit. Its following bits are ignored.
- R13: `bus_rst` clears the frame in progress, `ber` and the attention history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst | input | 1 | Bus-level reset symbol |
| start_stb | input | 1 | Start symbol strobe |
| bit_stb | input | 1 | Data-bit symbol strobe |
| bit_val | input | 1 | Value of the data bit |
| bus_idle | input | 1 | Bus is inactive |
| dev_strap | input | 3 | This device's number |
| attn_en | input | 1 | Attention requests allowed |
| attn_obs | input | 1 | Attention seen on the bus from any device |
| status_rd | input | 1 | Device status register was read |
| ack_stb | output | 1 | Acknowledge symbol strobe |
| ack_val | output | 1 | Acknowledge value (1 = accepted) |
| wr_en | output | 1 | Register commit strobe |
| wr_addr | output | 5 | Committed register address |
| wr_data | output | 16 | Committed data, right-justified |
| ber | output | 1 | Sticky bus-error flag |
| attn_req | output | 1 | Attention request pulse |

## Verification
The hardest case to reach is an attention request held back by its gate and later released. To produce it, the bench causes a parity failure while `attn_en` is low, confirms that no request appears, and then raises the enable. In a separate run it pulses `attn_obs` before the failure, so the once-per-read gate is already closed and the request must stay silent. Frames that are cut short, stretched or broken by a start strobe are built bit by bit. The bench computes parity itself, so the parity bit can be placed at any bit position.

// File: rtl/swb_pkg.sv
// Package: shared types for the single-wire bus write slave.
// Assumes nothing beyond IEEE 1800-2017 types.
package swb_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HDR  = 2'd1,
        RX_DATA = 2'd2,
        RX_PAR  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/swb_size_lut.sv
// Register size lookup: maps an internal address to its data width.
// Addresses below NARROW_N are narrow, the next WIDE_N are wide, the rest undefined.
module swb_size_lut #(
    parameter int ADR_W    = 5,
    parameter int NARROW_N = 8,
    parameter int WIDE_N   = 8
) (
    input  logic [ADR_W-1:0] addr,
    output logic             is_wide,
    output logic             is_defined
);
    localparam int LIMIT = NARROW_N + WIDE_N;

    logic [31:0] addr32;

    // Compare the address against the size boundaries.
    always_comb begin
        addr32     = 32'(addr);
        is_defined = (addr32 < 32'(LIMIT));
        is_wide    = is_defined && (addr32 >= 32'(NARROW_N));
    end
endmodule

// File: rtl/swb_rx_fsm.sv
// Frame receiver: assembles header and data from bit strobes, tracks parity,
// issues the acknowledge and the commit strobe. Assumes strobes last one cycle
// and that start_stb wins over bit_stb in the same cycle.
module swb_rx_fsm
    import swb_pkg::*;
#(
    parameter int DEV_W    = 3,
    parameter int ADR_W    = 5,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16,
    parameter int NARROW_N = 8,
    parameter int WIDE_N   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              start_stb,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [DEV_W-1:0]  dev_strap,
    output logic              ack_stb,
    output logic              ack_val,
    output logic              wr_en,
    output logic [ADR_W-1:0]  wr_addr,
    output logic [WIDE_W-1:0] wr_data
);
    localparam int HDR_W = DEV_W + ADR_W + 1;
    localparam int MAXN  = (HDR_W > WIDE_W) ? HDR_W : WIDE_W;
    localparam int CNT_W = $clog2(MAXN) + 1;
    localparam logic [CNT_W-1:0] HDR_LAST    = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_W - 1);
    localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_W - 1);

    rx_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [HDR_W-1:0]  hdr_nxt;
    logic [WIDE_W-1:0] dat_q;
    logic              par_q;
    logic              mine_q;
    logic              wide_q;
    logic              def_q;
    logic [ADR_W-1:0]  addr_q;
    logic [DEV_W-1:0]  hdr_dev;
    logic [ADR_W-1:0]  hdr_addr;
    logic              hdr_rd;
    logic              lut_wide;
    logic              lut_def;
    logic              par_ok;

    // Split the header as it would look with the current bit shifted in.
    always_comb begin
        hdr_nxt  = {hdr_q[HDR_W-2:0], bit_val};
        hdr_dev  = hdr_nxt[HDR_W-1 -: DEV_W];
        hdr_addr = hdr_nxt[ADR_W:1];
        hdr_rd   = hdr_nxt[0];
        par_ok   = ((par_q ^ bit_val) == 1'b0);
    end

    swb_size_lut #(
        .ADR_W   (ADR_W),
        .NARROW_N(NARROW_N),
        .WIDE_N  (WIDE_N)
    ) size_i (
        .addr      (hdr_addr),
        .is_wide   (lut_wide),
        .is_defined(lut_def)
    );

    // Frame sequencer: header, data, parity, then acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            hdr_q   <= '0;
            dat_q   <= '0;
            par_q   <= 1'b0;
            mine_q  <= 1'b0;
            wide_q  <= 1'b0;
            def_q   <= 1'b0;
            addr_q  <= '0;
            ack_stb <= 1'b0;
            ack_val <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            ack_stb <= 1'b0;
            wr_en   <= 1'b0;
            if (start_stb) begin
                state_q <= RX_HDR;
                cnt_q   <= '0;
                hdr_q   <= '0;
                par_q   <= 1'b0;
            end else if (bit_stb) begin
                case (state_q)
                    RX_HDR: begin
                        hdr_q <= hdr_nxt;
                        par_q <= par_q ^ bit_val;
                        if (cnt_q == HDR_LAST) begin
                            cnt_q   <= '0;
                            dat_q   <= '0;
                            mine_q  <= (hdr_dev == dev_strap);
                            addr_q  <= hdr_addr;
                            wide_q  <= lut_wide;
                            def_q   <= lut_def;
                            state_q <= hdr_rd ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        dat_q <= {dat_q[WIDE_W-2:0], bit_val};
                        par_q <= par_q ^ bit_val;
                        if (cnt_q == (wide_q ? WIDE_LAST : NARROW_LAST)) begin
                            state_q <= RX_PAR;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        state_q <= RX_IDLE;
                        if (mine_q) begin
                            ack_stb <= 1'b1;
                            ack_val <= def_q && par_ok;
                            wr_en   <= def_q && par_ok;
                            if (def_q && par_ok) begin
                                wr_addr <= addr_q;
                                wr_data <= dat_q;
                            end
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/swb_attn_ctrl.sv
// Error and attention control: keeps the sticky error flag and issues a gated,
// single-cycle attention request. Assumes nack_evt lasts one cycle.
module swb_attn_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst,
    input  logic nack_evt,
    input  logic status_rd,
    input  logic attn_en,
    input  logic bus_idle,
    input  logic attn_obs,
    output logic ber,
    output logic attn_req
);
    logic pend_q;
    logic seen_q;
    logic fire;

    // A request may go out when pending, enabled, idle and not yet seen.
    always_comb begin
        fire = pend_q && attn_en && bus_idle && !seen_q;
    end

    // Update the error flag, the pending request and the seen gate.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst) begin
            ber      <= 1'b0;
            pend_q   <= 1'b0;
            seen_q   <= 1'b0;
            attn_req <= 1'b0;
        end else begin
            attn_req <= fire;
            if (nack_evt) begin
                ber <= 1'b1;
            end else if (status_rd) begin
                ber <= 1'b0;
            end
            if (nack_evt) begin
                pend_q <= 1'b1;
            end else if (status_rd || fire) begin
                pend_q <= 1'b0;
            end
            if (status_rd) begin
                seen_q <= 1'b0;
            end else if (fire || attn_obs) begin
                seen_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/swb_wr_slave.sv
// Top: write path of a single-wire bus slave. Joins the frame receiver with
// the error and attention control. Assumes decoded, single-cycle symbols.
module swb_wr_slave #(
    parameter int DEV_W    = 3,
    parameter int ADR_W    = 5,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16,
    parameter int NARROW_N = 8,
    parameter int WIDE_N   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              start_stb,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              bus_idle,
    input  logic [DEV_W-1:0]  dev_strap,
    input  logic              attn_en,
    input  logic              attn_obs,
    input  logic              status_rd,
    output logic              ack_stb,
    output logic              ack_val,
    output logic              wr_en,
    output logic [ADR_W-1:0]  wr_addr,
    output logic [WIDE_W-1:0] wr_data,
    output logic              ber,
    output logic              attn_req
);
    logic nack_evt;

    // A refused acknowledge is the error event.
    always_comb begin
        nack_evt = ack_stb && !ack_val;
    end

    swb_rx_fsm #(
        .DEV_W   (DEV_W),
        .ADR_W   (ADR_W),
        .NARROW_W(NARROW_W),
        .WIDE_W  (WIDE_W),
        .NARROW_N(NARROW_N),
        .WIDE_N  (WIDE_N)
    ) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rst  (bus_rst),
        .start_stb(start_stb),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .dev_strap(dev_strap),
        .ack_stb  (ack_stb),
        .ack_val  (ack_val),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    swb_attn_ctrl attn_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rst  (bus_rst),
        .nack_evt (nack_evt),
        .status_rd(status_rd),
        .attn_en  (attn_en),
        .bus_idle (bus_idle),
        .attn_obs (attn_obs),
        .ber      (ber),
        .attn_req (attn_req)
    );
endmodule

// File: rtl/swb_wr_slave_chk.sv
// Checker: protocol properties of the write slave, bound to the top module.
module swb_wr_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_rst,
    input logic start_stb,
    input logic bit_stb,
    input logic bus_idle,
    input logic attn_en,
    input logic status_rd,
    input logic ack_stb,
    input logic ack_val,
    input logic wr_en,
    input logic ber,
    input logic attn_req
);
    // R4
    commit_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ack_stb && ack_val));

    // R3
    ack_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |-> $past(bit_stb));

    // R5
    nack_sets_ber_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !ack_val && !bus_rst) |=> ber);

    // R5
    ber_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ber && !status_rd && !bus_rst) |=> ber);

    // R6
    attn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attn_req |-> $past(attn_en && bus_idle));

    // R6
    attn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attn_req |=> !attn_req);

    // R7
    start_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> !ack_stb);

    // R13
    bus_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (!ber && !ack_stb && !attn_req));
endmodule

bind swb_wr_slave swb_wr_slave_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rst  (bus_rst),
    .start_stb(start_stb),
    .bit_stb  (bit_stb),
    .bus_idle (bus_idle),
    .attn_en  (attn_en),
    .status_rd(status_rd),
    .ack_stb  (ack_stb),
    .ack_val  (ack_val),
    .wr_en    (wr_en),
    .ber      (ber),
    .attn_req (attn_req)
);

// File: tb/swb_wr_slave_tb.sv
`timescale 1ns/1ps
// Directed bench for the single-wire bus write slave.
module swb_wr_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        start_stb = 1'b0;
    logic        bit_stb = 1'b0;
    logic        bit_val = 1'b0;
    logic        bus_idle = 1'b1;
    logic [2:0]  dev_strap = 3'd5;
    logic        attn_en = 1'b1;
    logic        attn_obs = 1'b0;
    logic        status_rd = 1'b0;
    logic        ack_stb;
    logic        ack_val;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [15:0] wr_data;
    logic        ber;
    logic        attn_req;

    int  n_chk = 0;
    int  n_fail = 0;
    int  attn_cnt = 0;
    bit  tb_par = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    swb_wr_slave dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .start_stb(start_stb),
        .bit_stb(bit_stb), .bit_val(bit_val), .bus_idle(bus_idle),
        .dev_strap(dev_strap), .attn_en(attn_en), .attn_obs(attn_obs),
        .status_rd(status_rd), .ack_stb(ack_stb), .ack_val(ack_val),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ber(ber),
        .attn_req(attn_req)
    );

    // Count attention pulses away from the clock edge.
    always @(negedge clk) if (rst_n && attn_req) attn_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_start();
        @(negedge clk); start_stb = 1'b1; bus_idle = 1'b0;
        @(negedge clk); start_stb = 1'b0;
        tb_par = 1'b0;
    endtask

    task automatic send_bit(input bit v);
        @(negedge clk); bit_stb = 1'b1; bit_val = v;
        @(negedge clk); bit_stb = 1'b0;
        tb_par ^= v;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_hdr(input logic [2:0] dev, input logic [4:0] adr, input bit rd);
        send_start();
        send_bits({24'd0, dev, adr}, 8);
        send_bit(rd);
    endtask

    // Parity bit; flip = 1 sends the wrong value. Returns with ack visible.
    task automatic send_par(input bit flip);
        bit p;
        p = tb_par ^ flip;
        send_bit(p);
        bus_idle = 1'b1;
    endtask

    task automatic pulse_status();
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk(!ack_stb && !wr_en && !ber && !attn_req, "R13 reset", {ack_stb, wr_en, ber, attn_req}, 0);
    endtask

    task automatic t_good8();
        send_hdr(3'd5, 5'd3, 1'b0);
        send_bits(32'hA5, 8);
        send_par(1'b0);
        chk(ack_stb && ack_val, "R3 ack good", {ack_stb, ack_val}, 3);
        chk(wr_en && wr_addr == 5'd3 && wr_data == 16'h00A5, "R1 R4 commit narrow",
            {wr_en, wr_addr, wr_data}, {1'b1, 5'd3, 16'h00A5});
        idle(1);
        chk(!ack_stb && !wr_en, "R3 ack one cycle", {ack_stb, wr_en}, 0);
    endtask

    task automatic t_good16();
        send_hdr(3'd5, 5'd10, 1'b0);
        send_bits(32'hBEEF, 16);
        send_par(1'b0);
        chk(ack_stb && ack_val && wr_en && wr_data == 16'hBEEF && wr_addr == 5'd10,
            "R2 wide write", wr_data, 16'hBEEF);
    endtask

    task automatic t_bad_par();
        int a0;
        a0 = attn_cnt;
        send_hdr(3'd5, 5'd2, 1'b0);
        send_bits(32'h3C, 8);
        send_par(1'b1);
        chk(ack_stb && !ack_val && !wr_en, "R3 R4 parity nack", {ack_stb, ack_val, wr_en}, 4);
        idle(1);
        chk(ber, "R5 ber set", ber, 1);
        idle(5);
        chk(attn_cnt == a0 + 1, "R6 attention once", attn_cnt - a0, 1);
        send_hdr(3'd5, 5'd2, 1'b0);
        send_bits(32'h3C, 8);
        send_par(1'b1);
        idle(6);
        chk(attn_cnt == a0 + 1 && ber, "R6 gate closed until read", attn_cnt - a0, 1);
        pulse_status();
        idle(1);
        chk(!ber, "R5 status read clears", ber, 0);
    endtask

    task automatic t_abort();
        int a0;
        a0 = attn_cnt;
        send_hdr(3'd5, 5'd4, 1'b0);
        send_bits(32'h9, 4);
        send_hdr(3'd5, 5'd4, 1'b0);
        send_bits(32'h5A, 8);
        send_par(1'b0);
        chk(ack_stb && ack_val && wr_data == 16'h005A, "R7 restart completes", wr_data, 16'h005A);
        idle(6);
        chk(!ber && attn_cnt == a0, "R7 abort silent", {ber, 8'(attn_cnt - a0)}, 0);
    endtask

    task automatic t_extra();
        bit keep;
        send_hdr(3'd5, 5'd1, 1'b0);
        send_bits(32'h81, 8);
        send_par(1'b0);
        chk(ack_stb && ack_val && wr_data == 16'h0081, "R8 extra bit as parity", wr_data, 16'h0081);
        send_bit(1'b1);
        send_bit(1'b0);
        chk(!ack_stb && !wr_en, "R8 trailing bits ignored", {ack_stb, wr_en}, 0);
        send_hdr(3'd5, 5'd1, 1'b0);
        send_bits(32'h0F, 8);
        keep = tb_par;
        send_bit(~keep);
        bus_idle = 1'b1;
        chk(ack_stb && !ack_val && !wr_en, "R8 extra mismatch nacks", {ack_stb, ack_val}, 2);
        pulse_status();
    endtask

    task automatic t_short();
        send_hdr(3'd5, 5'd6, 1'b0);
        send_bits(32'h1A, 5);
        idle(60);
        chk(!ack_stb && !wr_en && !ber, "R9 waits", {ack_stb, wr_en, ber}, 0);
        send_bits(32'h5, 3);
        send_par(1'b0);
        chk(ack_stb && ack_val && wr_data == 16'h00D5, "R9 late completion", wr_data, 16'h00D5);
    endtask

    task automatic t_other_dev();
        int a0;
        a0 = attn_cnt;
        send_hdr(3'd2, 5'd3, 1'b0);
        send_bits(32'h77, 8);
        send_par(1'b1);
        chk(!ack_stb && !wr_en, "R10 no ack foreign", {ack_stb, wr_en}, 0);
        idle(6);
        chk(!ber && attn_cnt == a0, "R10 no error foreign", ber, 0);
    endtask

    task automatic t_undef();
        send_hdr(3'd5, 5'd20, 1'b0);
        send_bits(32'h11, 8);
        send_par(1'b0);
        chk(ack_stb && !ack_val && !wr_en, "R11 undefined addr nack", {ack_stb, ack_val}, 2);
        idle(1);
        pulse_status();
    endtask

    task automatic t_read();
        send_hdr(3'd5, 5'd3, 1'b1);
        send_bits(32'h0, 8);
        send_par(1'b0);
        chk(!ack_stb && !wr_en, "R12 read ignored", {ack_stb, wr_en}, 0);
    endtask

    task automatic t_attn_en();
        int a0;
        a0 = attn_cnt;
        attn_en = 1'b0;
        send_hdr(3'd5, 5'd2, 1'b0);
        send_bits(32'h01, 8);
        send_par(1'b1);
        idle(6);
        chk(attn_cnt == a0 && ber, "R6 held while disabled", attn_cnt - a0, 0);
        attn_en = 1'b1;
        idle(4);
        chk(attn_cnt == a0 + 1, "R6 released on enable", attn_cnt - a0, 1);
        pulse_status();
    endtask

    task automatic t_attn_obs();
        int a0;
        a0 = attn_cnt;
        @(negedge clk); attn_obs = 1'b1;
        @(negedge clk); attn_obs = 1'b0;
        send_hdr(3'd5, 5'd2, 1'b0);
        send_bits(32'h02, 8);
        send_par(1'b1);
        idle(6);
        chk(attn_cnt == a0 && ber, "R6 other attention blocks", attn_cnt - a0, 0);
        pulse_status();
    endtask

    task automatic t_bus_rst();
        send_hdr(3'd5, 5'd2, 1'b0);
        send_bits(32'h02, 8);
        send_par(1'b1);
        idle(2);
        send_hdr(3'd5, 5'd3, 1'b0);
        send_bits(32'hA, 4);
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
        chk(!ber, "R13 bus reset clears ber", ber, 0);
        send_bits(32'h5, 4);
        send_par(1'b0);
        chk(!ack_stb && !wr_en, "R13 frame dropped", {ack_stb, wr_en}, 0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_good8();
        t_good16();
        t_bad_par();
        t_abort();
        t_extra();
        t_short();
        t_other_dev();
        t_undef();
        t_read();
        t_attn_en();
        t_attn_obs();
        t_bus_rst();
        idle(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule